// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Filter Using Distributed Arithmetic

This block is a fixed-coefficient, linear-phase FIR filter with no multipliers. Each input sample arrives one bit per clock, least significant bit first. A strobe marks the first bit. A chain of per-tap shift registers forms the delay line. The filter has odd length and mirror-image coefficients, so each pair of taps that share a coefficient is first summed by a bit-serial adder with its own carry flip-flop. The middle tap passes through alone.

In each bit period, one bit from every folded input addresses a small table. Each table entry holds the sum of the coefficients whose address bit is set. A shift-and-add accumulator weights each table output by the significance of its bit period. It subtracts the output of the sign period. At the end of the frame the accumulator holds the full convolution sum, which the block latches as a parallel result word.

Top module: `bitserial_sym_fir`

## Requirements
- R1: After each frame, `yOut` equals the sum over i of Ci·x[n-i], for i from 0 to NTAPS-1. x[n] is the newest sample. Ci = COEF[min(i, NTAPS-1-i)], where COEF[j] is the signed field COEF_VEC[j*CW +: CW].
- R2: A frame is W+1 consecutive clocks. `sampleStart` is high on the first clock. In clocks 0 to W-1 of the frame, `dataBit` carries sample bits 0 to W-1, least significant first. Samples are W-bit two's complement.
- R3: The value of `dataBit` in clock W of a frame, and in every clock outside a frame, has no effect on any result.
- R4: `outValid` is high for exactly one clock: the clock after the last clock of a frame. `yOut` changes only when `outValid` is high and holds its value until then.
- R5: During reset and after it, `yOut` is 0 and `outValid` is 0 until the first frame completes. Reset also clears the delay line, so samples sent before reset contribute nothing.
- R6: Full-scale inputs (all samples at -2^(W-1), or at 2^(W-1)-1, or signs matched to the coefficient signs) give exact results with no overflow.
- R7: Idle gaps of any length between frames do not change the results.
- R8: A single sample of value 1, followed by zeros, produces the coefficients C0 to C(NTAPS-1) in order on successive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStart | input | 1 | High on the first clock of a sample frame |
| dataBit | input | 1 | Serial sample bit, least significant first |
| yOut | output | OW | Signed filter result, held between frames |
| outValid | output | 1 | One-clock pulse when a new result is on yOut |

## Verification
The bench builds the block with 8-bit samples, 7 taps and 12-bit coefficients of mixed sign, which gives a 4-bit table address and 9-clock frames. With seven taps, the pre-adders see genuinely different pairs, so carries propagate through the sign-extension period. Seven consecutive full-scale frames drive the accumulator to its extreme values. Randomized samples and gaps are mixed with an impulse run and with deliberately hostile bits in the sign-extension clock and in idle clocks.

// File: rtl/bsfir_pkg.sv
package bsfir_pkg;
  typedef struct packed {
    logic first;    // clock 0 of a frame
    logic active;   // any clock inside a frame
    logic shiftEn;  // clocks 0..W-1: sample bits are present
    logic lastBit;  // clock W: sign-extension period
  } bsStrobe_t;
endpackage

// File: rtl/bsfir_ctrl.sv
module bsfir_ctrl
  import bsfir_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleStart,
  output bsStrobe_t stb
);
  localparam int CNTW = $clog2(W + 1);

  logic [CNTW-1:0] bitCnt;
  logic            busy;
  logic [CNTW-1:0] period;
  logic            running;

  assign period  = sampleStart ? '0 : bitCnt;
  assign running = sampleStart | busy;

  always_comb begin
    stb.first   = sampleStart;
    stb.active  = running;
    stb.shiftEn = running && (period < CNTW'(W));
    stb.lastBit = running && (period == CNTW'(W));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      busy   <= 1'b0;
    end else if (running && (period < CNTW'(W))) begin
      bitCnt <= period + CNTW'(1);
      busy   <= 1'b1;
    end else begin
      bitCnt <= '0;
      busy   <= 1'b0;
    end
  end

  // R2
  frame_continue_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |=> stb.active);
  // R4
  last_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lastBit |=> !stb.lastBit);
endmodule

// File: rtl/bsfir_datapath.sv
module bsfir_datapath
  import bsfir_pkg::*;
#(
  parameter int W      = 8,
  parameter int NTAPS  = 7,
  parameter int CW     = 12,
  parameter int NHALF  = (NTAPS + 1) / 2,
  parameter logic [NHALF*CW-1:0] COEF_VEC = '0,
  parameter int OW     = CW + $clog2(NHALF) + 1 + W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dataBit,
  input  bsStrobe_t            stb,
  output logic signed [OW-1:0] yOut,
  output logic                 outValid
);
  localparam int NPAIR = NHALF - 1;
  localparam int NSR   = NTAPS - 1;
  localparam int B     = W + 1;
  localparam int TW    = CW + $clog2(NHALF) + 1;
  localparam int NADDR = 2 ** NHALF;
  localparam int RW    = OW + 2;

  function automatic logic signed [TW-1:0] entrySum(int unsigned addr);
    logic signed [TW-1:0] s;
    logic signed [CW-1:0] c;
    s = '0;
    for (int j = 0; j < NHALF; j++) begin
      c = COEF_VEC[j*CW +: CW];
      if (addr[j]) s = s + TW'(c);
    end
    return s;
  endfunction

  // delay line: one W-bit shift register per older tap
  logic [W-1:0]     taps [NSR];
  logic [NTAPS-1:0] rawBit, heldBit, tapBit;

  assign rawBit[0] = dataBit;
  for (genvar i = 0; i < NSR; i++) begin : g_tap
    assign rawBit[i+1] = taps[i][0];
    always_ff @(posedge clk) begin
      if (!rstN)           taps[i] <= '0;
      else if (stb.shiftEn) taps[i] <= {rawBit[i], taps[i][W-1:1]};
    end
  end

  // sign extension: repeat the last bit seen during the extra period
  always_ff @(posedge clk) begin
    if (!rstN)            heldBit <= '0;
    else if (stb.shiftEn) heldBit <= rawBit;
  end
  assign tapBit = stb.shiftEn ? rawBit : heldBit;

  // folding pre-adders
  logic [NHALF-1:0] addr;
  logic [NPAIR-1:0] carry;
  for (genvar j = 0; j < NPAIR; j++) begin : g_fold
    logic a, b, cin;
    assign a       = tapBit[j];
    assign b       = tapBit[NTAPS-1-j];
    assign cin     = stb.first ? 1'b0 : carry[j];
    assign addr[j] = a ^ b ^ cin;
    always_ff @(posedge clk) begin
      if (!rstN)           carry[j] <= 1'b0;
      else if (stb.active) carry[j] <= (a & b) | (a & cin) | (b & cin);
    end
  end
  assign addr[NHALF-1] = tapBit[NHALF-1];

  // partial-sum table
  logic signed [TW-1:0] lut [NADDR];
  for (genvar k = 0; k < NADDR; k++) begin : g_lut
    assign lut[k] = entrySum(k);
  end

  // scaling accumulator: add at the top, shift right each period
  logic signed [RW-1:0] acc, accBase, term, sumW, accNext;
  always_comb begin
    term    = RW'(lut[addr]);
    if (stb.lastBit) term = -term;
    accBase = stb.first ? '0 : acc;
    sumW    = accBase + (term <<< B);
    accNext = sumW >>> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      yOut     <= '0;
      outValid <= 1'b0;
    end else begin
      if (stb.active)  acc  <= accNext;
      if (stb.lastBit) yOut <= accNext[OW-1:0];
      outValid <= stb.lastBit;
    end
  end

  // R4
  valid_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lastBit |=> outValid);
  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(yOut) |-> outValid);
endmodule

// File: rtl/bitserial_sym_fir.sv
module bitserial_sym_fir
  import bsfir_pkg::*;
#(
  parameter int W      = 8,
  parameter int NTAPS  = 7,
  parameter int CW     = 12,
  parameter logic [((NTAPS+1)/2)*CW-1:0] COEF_VEC = {12'sd511, 12'sd155, -12'sd40, 12'sd3},
  localparam int OW    = CW + $clog2((NTAPS + 1) / 2) + 1 + W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleStart,
  input  logic                 dataBit,
  output logic signed [OW-1:0] yOut,
  output logic                 outValid
);
  bsStrobe_t stb;

  bsfir_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStart(sampleStart), .stb(stb)
  );

  bsfir_datapath #(
    .W(W), .NTAPS(NTAPS), .CW(CW), .NHALF((NTAPS + 1) / 2),
    .COEF_VEC(COEF_VEC), .OW(OW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dataBit(dataBit), .stb(stb),
    .yOut(yOut), .outValid(outValid)
  );
endmodule

// File: tb/bitserial_sym_fir_tb.sv
module bitserial_sym_fir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NTAPS = 7;
  localparam int CW = 12;
  localparam int OW = CW + $clog2((NTAPS + 1) / 2) + 1 + W + 1;
  localparam int C0 = 3, C1 = -40, C2 = 155, C3 = 511;
  localparam logic [4*CW-1:0] VEC = {12'(C3), 12'(C2), 12'(C1), 12'(C0)};

  logic clk = 0, rstN = 0, sampleStart = 0, dataBit = 0;
  logic signed [OW-1:0] yOut;
  logic outValid;
  int checks = 0, errors = 0;
  int hist [NTAPS];

  always #(CLK_PERIOD/2) clk = ~clk;

  bitserial_sym_fir #(.W(W), .NTAPS(NTAPS), .CW(CW), .COEF_VEC(VEC)) u_dut (
    .clk(clk), .rstN(rstN), .sampleStart(sampleStart), .dataBit(dataBit),
    .yOut(yOut), .outValid(outValid)
  );

  function automatic int tapCoef(int i);
    int j = (i < NTAPS - i - 1) ? i : NTAPS - 1 - i;
    case (j)
      0: return C0;
      1: return C1;
      2: return C2;
      default: return C3;
    endcase
  endfunction

  function automatic int model();
    int s = 0;
    for (int i = 0; i < NTAPS; i++) s += hist[i] * tapCoef(i);
    return s;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive one frame starting just after a falling edge; badExtra forces
  // hostile values on the sign-extension clock and on idle clocks
  task automatic sendFrame(int s, int gap, string tag, bit badExtra);
    int held;
    for (int b = 0; b <= W; b++) begin
      sampleStart = (b == 0);
      if (b < W) dataBit = s[b];
      else       dataBit = badExtra ? ~s[W-1] : 1'($urandom);
      @(negedge clk);
    end
    sampleStart = 0;
    for (int i = NTAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    check({tag, " valid"}, int'(outValid), 1);
    check(tag, int'(yOut), model());
    held = int'(yOut);
    for (int g = 0; g < gap; g++) begin
      dataBit = badExtra ? 1'b1 : 1'($urandom);
      @(negedge clk);
      check("R4 pulse", int'(outValid), 0);
      check("R7 hold", int'(yOut), held);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 yOut", int'(yOut), 0);
    check("R5 valid", int'(outValid), 0);
    rstN = 1;
    @(negedge clk);
    check("R5 after release", int'(outValid), 0);

    // R2: asymmetric bit patterns expose bit order
    sendFrame(1, 0, "R2", 0);
    sendFrame(-128, 1, "R2", 0);
    sendFrame(8'sh35, 0, "R2", 0);

    // R8: impulse response
    for (int i = 0; i < NTAPS; i++) sendFrame(0, 0, "R1", 0);
    for (int k = 0; k < NTAPS; k++) begin
      sendFrame((k == 0) ? 1 : 0, 0, "R8", 0);
      check("R8 coef", int'(yOut), tapCoef(k));
    end

    // R6: full-scale extremes
    for (int i = 0; i < NTAPS; i++) sendFrame(-128, 0, "R6 min", 0);
    for (int i = 0; i < NTAPS; i++) sendFrame(127, 0, "R6 max", 0);
    for (int i = 0; i < NTAPS; i++)
      sendFrame((tapCoef(NTAPS - 1 - i) < 0) ? 127 : -128, 0, "R6 matched", 0);

    // R3: hostile sign-extension and idle bits
    for (int i = 0; i < 10; i++)
      sendFrame(int'($signed(8'($urandom))), 3, "R3", 1);

    // R1 / R7: random samples with random gaps
    for (int i = 0; i < 80; i++)
      sendFrame(int'($signed(8'($urandom))), int'($urandom % 4), "R1", 0);

    // R5: reset mid-run clears history
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    check("R5 mid-run yOut", int'(yOut), 0);
    rstN = 1;
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
    @(negedge clk);
    sendFrame(1, 0, "R5 cleared", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule